// File: doc/BRIEF.md
# SIMD Floating-Point Exception Control and Status Register

This block is the single 32-bit control and status word of a SIMD floating-point unit. Software reads and writes it through a plain register port. It holds six sticky exception flags, six exception enables, a two-bit rounding selector, and two operand and result handling modes. The arithmetic datapath reads the rounding selector and the two mode bits from dedicated output pins.

Each cycle the datapath reports a six-bit exception vector. Every reported exception sets its sticky flag. An exception whose enable bit is set is only recorded. An exception whose enable bit is clear also raises a one-cycle trap request, which comes with a vector naming the exceptions that caused it. A trap handler can then read the flags to see what happened. A software write and a datapath report can land in the same cycle, and no event is dropped when they do. Only the low 16 bits are defined. The upper half reads as zero, and a write that touches it can be reported on a dedicated pulse.

Top module: `fpx_csr`

## Requirements
- R1: After reset the register reads 0x0000_1F80: all enables set, rounding selector 00, both mode bits clear, all flags clear. The trap request and the reserved-write pulse are low.
- R2: Bits 31:16 always read zero. Writing ones to them changes no readable bit.
- R3: A write whose data has any of bits 31:16 set drives rsv_err_o high for exactly the one cycle after that write. The defined bits 15:0 of that write still take effect.
- R4: Flags sit at bits 5:0 and are indexed by exception: 0 invalid, 1 denormal operand, 2 divide-by-zero, 3 overflow, 4 underflow, 5 inexact. Bit i of evt_i reports the same exception as flag i.
- R5: Enable bits sit at bits 12:7, with exception i at bit 7+i. A reported exception whose enable is 1 sets flag i and raises no trap.
- R6: A reported exception whose enable is 0 drives trap_req_o high for exactly the one cycle after the report, with trap_vec_o = evt_i & ~enable. Its flag is set as well.
- R7: Flags are sticky. Cycles with evt_i = 0 and no write leave them unchanged, and only a software write clears them.
- R8: When a write and a report occur in the same cycle, the flags become the written bits 5:0 ORed with evt_i.
- R9: Bits 14:13 drive round_mode_o: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R10: Bit 15 drives flush_res_o, which zeroes underflowing results. Bit 6 drives zero_denorm_in_o, which treats denormal inputs as zero.
- R11: A report that lands in the same cycle as a write is routed using the enables held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Current register contents |
| evt_i | input | 6 | Exceptions raised by the datapath this cycle |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_vec_o | output | 6 | Unmasked exceptions behind the trap request |
| round_mode_o | output | 2 | Rounding selector to the datapath |
| flush_res_o | output | 1 | Zero underflowing results |
| zero_denorm_in_o | output | 1 | Treat denormal operands as zero |
| rsv_err_o | output | 1 | Pulse after a write to reserved bits |

## Verification
A corrupted flag bit shows up on rd_data_o one cycle after the event or write that produced it. Because the flags are sticky, it then stays visible until the next write. A wrong enable bit misroutes every later report of that exception: either a spurious trap pulse appears on the cycle after the report, or an expected pulse is missing. That routing is swept over every pair of enable pattern and event pattern, so any single misrouted bit shows within one report. A reserved-bit or mode-field fault appears on the read port or on the datapath pins on the cycle after the write.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int N_EXC     = 6;
   localparam int DEF_W     = 16;
   localparam int FLAG_LSB  = 0;
   localparam int DZ_BIT    = 6;
   localparam int MASK_LSB  = 7;
   localparam int RND_LSB   = 13;
   localparam int FLUSH_BIT = 15;
   localparam int MODE_W    = DEF_W - DZ_BIT;

   typedef enum logic [1:0] {
      RND_NEAR  = 2'b00,
      RND_DOWN  = 2'b01,
      RND_UP    = 2'b10,
      RND_TRUNC = 2'b11
   } rnd_e;

   typedef struct packed {
      logic       flush;
      rnd_e       rnd;
      logic [N_EXC-1:0] mask;
      logic       dz;
   } mode_t;
endpackage

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   input  logic [N-1:0] evt_i,
   output logic [N-1:0] flags_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_o[i] <= 1'b0;
         else if (wr_i)
            flags_o[i] <= wdata_i[i] | evt_i[i];
         else if (evt_i[i])
            flags_o[i] <= 1'b1;
      end
   end

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && evt_i == '0) |=> flags_o == $past(flags_o));

   p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> (flags_o & $past(evt_i)) == $past(evt_i));

   p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> flags_o == ($past(wdata_i) | $past(evt_i)));
endmodule

// File: rtl/fpx_ctrl_fields.sv
module fpx_ctrl_fields
   import fpx_pkg::*;
#(
   parameter int N = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [MODE_W-1:0] wdata_i,
   output logic [N-1:0]      mask_o,
   output logic              dz_o,
   output rnd_e              rnd_o,
   output logic              flush_o
);
   localparam int M_LO = MASK_LSB - DZ_BIT;
   localparam int R_LO = RND_LSB - DZ_BIT;
   localparam int F_LO = FLUSH_BIT - DZ_BIT;

   mode_t mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q.flush <= 1'b0;
         mode_q.rnd   <= RND_NEAR;
         mode_q.mask  <= '1;
         mode_q.dz    <= 1'b0;
      end else if (wr_i) begin
         mode_q.flush <= wdata_i[F_LO];
         mode_q.rnd   <= rnd_e'(wdata_i[R_LO+1:R_LO]);
         mode_q.mask  <= wdata_i[M_LO+N-1:M_LO];
         mode_q.dz    <= wdata_i[0];
      end
   end

   assign mask_o  = mode_q.mask;
   assign dz_o    = mode_q.dz;
   assign rnd_o   = mode_q.rnd;
   assign flush_o = mode_q.flush;

   p_round_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> rnd_o == $past(wdata_i[R_LO+1:R_LO]));

   p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(flush_o) && $stable(dz_o) && $stable(mask_o));
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] mask_i,
   output logic         trap_req_o,
   output logic [N-1:0] trap_vec_o
);
   logic [N-1:0] open_evt;
   assign open_evt = evt_i & ~mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_req_o <= 1'b0;
         trap_vec_o <= '0;
      end else begin
         trap_req_o <= |open_evt;
         trap_vec_o <= open_evt;
      end
   end

   p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & ~mask_i) == '0) |=> !trap_req_o);

   p_trap_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req_o |-> trap_vec_o != '0);
endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
   import fpx_pkg::*;
#(
   parameter int NUM_EXC     = 6,
   parameter int REG_W       = 32,
   parameter bit FLAG_RSV_WR = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [REG_W-1:0]   wr_data_i,
   output logic [REG_W-1:0]   rd_data_o,
   input  logic [NUM_EXC-1:0] evt_i,
   output logic               trap_req_o,
   output logic [NUM_EXC-1:0] trap_vec_o,
   output logic [1:0]         round_mode_o,
   output logic               flush_res_o,
   output logic               zero_denorm_in_o,
   output logic               rsv_err_o
);
   localparam int RSV_W = REG_W - DEF_W;

   if (NUM_EXC != N_EXC) begin : g_bad_exc
      $error("fpx_csr: NUM_EXC must equal the defined flag count");
   end
   if (REG_W <= DEF_W) begin : g_bad_w
      $error("fpx_csr: REG_W must exceed the defined field width");
   end

   logic [NUM_EXC-1:0] flags;
   logic [NUM_EXC-1:0] mask;
   logic               dz;
   rnd_e               rnd;
   logic               flush;

   fpx_flag_bank #(.N(NUM_EXC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_en_i),
      .wdata_i (wr_data_i[FLAG_LSB+NUM_EXC-1:FLAG_LSB]),
      .evt_i   (evt_i),
      .flags_o (flags)
   );

   fpx_ctrl_fields #(.N(NUM_EXC)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_en_i),
      .wdata_i (wr_data_i[DEF_W-1:DZ_BIT]),
      .mask_o  (mask),
      .dz_o    (dz),
      .rnd_o   (rnd),
      .flush_o (flush)
   );

   fpx_trap_gen #(.N(NUM_EXC)) u_trap (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .mask_i     (mask),
      .trap_req_o (trap_req_o),
      .trap_vec_o (trap_vec_o)
   );

   if (FLAG_RSV_WR) begin : g_rsv_flag
      logic rsv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rsv_q <= 1'b0;
         else        rsv_q <= wr_en_i && (wr_data_i[REG_W-1:DEF_W] != '0);
      end
      assign rsv_err_o = rsv_q;

      p_rsv_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && wr_data_i[REG_W-1:DEF_W] != '0) |=> rsv_err_o);
   end else begin : g_rsv_drop
      assign rsv_err_o = 1'b0;
   end

   assign rd_data_o = {{RSV_W{1'b0}}, flush, rnd, mask, dz, flags};

   assign round_mode_o     = rnd;
   assign flush_res_o      = flush;
   assign zero_denorm_in_o = dz;

   p_trap_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req_o |-> (flags & trap_vec_o) == trap_vec_o);

   p_rsv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_err_o |=> !rsv_err_o || $past(wr_en_i));
endmodule

// File: tb/test_fpx_csr.sv
module test_fpx_csr;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [5:0]  evt = '0;
   logic [31:0] rd_data;
   logic        trap_req;
   logic [5:0]  trap_vec;
   logic [1:0]  round_mode;
   logic        flush_res;
   logic        zero_dn;
   logic        rsv_err;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpx_csr i_fpx_csr (
      .clk              (clk),
      .rst_n            (rst_n),
      .wr_en_i          (wr_en),
      .wr_data_i        (wr_data),
      .rd_data_o        (rd_data),
      .evt_i            (evt),
      .trap_req_o       (trap_req),
      .trap_vec_o       (trap_vec),
      .round_mode_o     (round_mode),
      .flush_res_o      (flush_res),
      .zero_denorm_in_o (zero_dn),
      .rsv_err_o        (rsv_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sw_write(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d; evt = '0;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 read", rd_data, 32'h0000_1F80);
      check("R1 trap", {31'd0, trap_req}, 32'd0);
      check("R1 rsv", {31'd0, rsv_err}, 32'd0);
      check("R1 modes", {29'd0, flush_res, round_mode}, 32'd0);
      check("R1 dz", {31'd0, zero_dn}, 32'd0);

      // R2 / R3: reserved bits
      sw_write(32'hFFFF_1F80);
      check("R2 reserved read zero", rd_data, 32'h0000_1F80);
      check("R3 rsv pulse", {31'd0, rsv_err}, 32'd1);
      step();
      check("R3 rsv one cycle", {31'd0, rsv_err}, 32'd0);
      sw_write(32'h0001_9F80);
      check("R3 defined bits still written", rd_data, 32'h0000_9F80);
      check("R3 rsv pulse again", {31'd0, rsv_err}, 32'd1);
      sw_write(32'h0000_1F80);
      check("R3 no pulse clean write", {31'd0, rsv_err}, 32'd0);

      // R9: rounding selector
      for (int r = 0; r < 4; r++) begin
         sw_write(32'h0000_1F80 | (r << 13));
         check("R9 round pin", {30'd0, round_mode}, r);
         check("R9 round read", rd_data, 32'h0000_1F80 | (r << 13));
      end

      // R10: mode bits
      sw_write(32'h0000_9F80);
      check("R10 flush on", {30'd0, flush_res, zero_dn}, 32'd2);
      sw_write(32'h0000_1FC0);
      check("R10 dz on", {30'd0, flush_res, zero_dn}, 32'd1);
      sw_write(32'h0000_1F80);

      // R4/R5/R6: sweep every enable pattern against every event pattern
      for (int m = 0; m < 64; m++) begin
         for (int e = 0; e < 64; e++) begin
            sw_write(32'(m) << 7);
            check("R6 pulse ended", {31'd0, trap_req}, 32'd0);
            evt = 6'(e);
            step();
            evt = '0;
            check("R4 R5 flags set", {26'd0, rd_data[5:0]}, 32'(e));
            check("R6 trap req", {31'd0, trap_req}, ((e & ~m & 63) != 0) ? 32'd1 : 32'd0);
            check("R6 trap vec", {26'd0, trap_vec}, 32'(e & ~m & 63));
         end
      end

      // R7: stickiness
      sw_write(32'h0000_1F80);
      evt = 6'b010000;
      step();
      evt = '0;
      for (int k = 0; k < 5; k++) begin
         step();
         check("R7 sticky", rd_data, 32'h0000_1F90);
      end
      sw_write(32'h0000_1F80);
      check("R7 cleared by write", rd_data, 32'h0000_1F80);

      // R8: collision
      wr_en = 1'b1; wr_data = 32'h0000_1F81; evt = 6'b100000;
      step();
      wr_en = 1'b0; evt = '0;
      check("R8 collision or", rd_data, 32'h0000_1FA1);
      wr_en = 1'b1; wr_data = 32'h0000_1F80; evt = 6'b001000;
      step();
      wr_en = 1'b0; evt = '0;
      check("R8 clear keeps event", rd_data, 32'h0000_1F88);

      // R11: routing uses enables before the same-cycle write
      sw_write(32'h0000_1F80);
      wr_en = 1'b1; wr_data = 32'h0000_0000; evt = 6'b000001;
      step();
      wr_en = 1'b0; evt = '0;
      check("R11 old mask used", {31'd0, trap_req}, 32'd0);
      evt = 6'b000001;
      step();
      evt = '0;
      check("R11 new mask next", {26'd0, trap_vec}, 32'd1);
      wr_en = 1'b1; wr_data = 32'h0000_1F80; evt = 6'b000100;
      step();
      wr_en = 1'b0; evt = '0;
      check("R11 open mask before write", {26'd0, trap_vec}, 32'd4);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule